// File: doc/BRIEF.md
# Address Monitor Wake Unit

This block is the per-thread hardware behind a monitor/wait pair of operations. A monitor command arms the unit on the aligned line that contains the supplied address. A write-back store seen on the snoop port and falling inside that line triggers the unit. A wait command then does one of two things. If the unit is already triggered, the wait finishes at once. Otherwise the thread enters a low-power sleep that ends when the watched line is written or when an interrupt-class event arrives.

Whether the unit is armed or triggered is not visible at the ports. It shows only in how the next wait behaves. The unit never re-arms itself, so software has to issue a monitor command before every wait that is meant to sleep. Power-management and fault events pass through without disturbing a pending trigger. Commands issued above privilege level 0 raise a fault pulse and have no other effect.

Top module: `addr_monitor_wake`

## Requirements
- R1: While rst_ni is low, and after it is released with no command, all outputs are 0: the unit is disarmed and not sleeping.
- R2: A monitor command at privilege 0 arms the unit on the LINE_BYTES-aligned line (64 bytes by default) holding mon_addr_i. A write-back store to any byte of that line triggers the unit.
- R3: A store whose address lies outside the armed line leaves the unit untriggered.
- R4: Only memory type 3'd6 (write-back) on snp_mtype_i can trigger. Stores of any other type are ignored.
- R5: A wait issued while the unit is triggered, or in the same cycle as a triggering store, pulses wait_done_o for one cycle after the command. It leaves sleeping_o at 0 and returns the unit to disarmed.
- R6: A wait issued while the unit is armed raises sleeping_o in the next cycle. A later triggering store drops sleeping_o and pulses wake_o for one cycle, with wake_cause_o = 0.
- R7: A wait issued while the unit is disarmed sleeps. Stores cannot end that sleep.
- R8: Event classes 0 (external interrupt) and 1 (non-maskable or system-management interrupt) wake a sleeping unit with wake_cause_o = 1. If a triggering store arrives in the same cycle, the cause is 0. An interrupt-class event while the unit is awake has no effect.
- R9: Completing or waking from a wait does not re-arm the unit. The next wait sleeps even if the old line is stored to.
- R10: Event classes 2 (power management) and 3 (fault) neither wake the unit nor clear a pending trigger.
- R11: A monitor or wait command at non-zero privilege pulses fault_o in the next cycle and changes neither the armed line nor the arm or sleep state.
- R12: Monitor and wait commands presented while sleeping_o is high are ignored, and they raise no fault.
- R13: A monitor command takes precedence over a wait command and over a store presented in the same cycle. The wait is dropped and the store is not checked against the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | PRIV_W | Privilege level of the issuing thread; 0 is the most privileged |
| mon_valid_i | input | 1 | Monitor command |
| mon_addr_i | input | ADDR_W | Address to watch |
| wait_valid_i | input | 1 | Wait command |
| snp_valid_i | input | 1 | Snooped store valid |
| snp_addr_i | input | ADDR_W | Snooped store address |
| snp_mtype_i | input | MT_W | Memory type of the store; 3'd6 is write-back |
| evt_valid_i | input | 1 | Wake/side event valid |
| evt_class_i | input | 2 | 0 interrupt, 1 NMI/SMI, 2 power management, 3 fault |
| sleeping_o | output | 1 | Thread is in the wait sleep state |
| wait_done_o | output | 1 | One-cycle pulse: wait completed without sleeping |
| wake_o | output | 1 | One-cycle pulse: sleep ended |
| wake_cause_o | output | 1 | Valid with wake_o: 0 store trigger, 1 interrupt |
| fault_o | output | 1 | One-cycle pulse: command refused for privilege |

## Verification
The bench builds the unit with ADDR_W = 12 and the default 64-byte line, which gives 64 lines in total. Random monitor and store addresses are drawn from only four of those lines. Stores therefore land in the armed line about a quarter of the time, and they hit a neighbouring line just as often. The random mix also contains non-write-back types, all four event classes and non-zero privilege levels. These reach the ordering corners without special setup: a store in the same cycle as a wait, a monitor in the same cycle as a store or a wait, a store together with an interrupt during sleep, and commands issued while asleep.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_ARMED = 2'd1,
    MON_TRIG  = 2'd2
  } mon_state_e;

  typedef enum logic [1:0] {
    EVC_INTR  = 2'd0,
    EVC_NMI   = 2'd1,
    EVC_POWER = 2'd2,
    EVC_FAULT = 2'd3
  } evt_class_e;

  localparam logic CAUSE_STORE = 1'b0;
  localparam logic CAUSE_INTR  = 1'b1;
endpackage

// File: rtl/amw_in_gate.sv
module amw_in_gate
  import amw_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              sleeping_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              mon_valid_i,
  input  logic              wait_valid_i,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_class_i,
  output logic              mon_go_o,
  output logic              wait_go_o,
  output logic              fault_o,
  output logic              intr_o
);
  logic priv_ok;
  logic awake;

  assign priv_ok   = (priv_i == '0);
  assign awake     = !sleeping_i;
  assign mon_go_o  = mon_valid_i && awake && priv_ok;
  // monitor wins over a same-cycle wait
  assign wait_go_o = wait_valid_i && !mon_valid_i && awake && priv_ok;
  assign fault_o   = (mon_valid_i || wait_valid_i) && awake && !priv_ok;

  always_comb begin
    intr_o = 1'b0;
    if (evt_valid_i) begin
      case (evt_class_e'(evt_class_i))
        EVC_INTR, EVC_NMI:    intr_o = 1'b1;
        EVC_POWER, EVC_FAULT: intr_o = 1'b0;
        default:              intr_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/amw_line_match.sv
module amw_line_match #(
  parameter int          ADDR_W     = 32,
  parameter int          LINE_BYTES = 64,
  parameter int          MT_W       = 3,
  parameter logic [2:0]  MT_WB      = 3'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [MT_W-1:0]   snp_mtype_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] base_q;
  logic              wb_store;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= load_addr_i & LINE_MASK;
  end

  assign wb_store = snp_valid_i && (snp_mtype_i == MT_W'(MT_WB));
  assign hit_o    = wb_store && ((snp_addr_i & LINE_MASK) == base_q);
endmodule

// File: rtl/amw_ctrl.sv
module amw_ctrl
  import amw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_go_i,
  input  logic wait_go_i,
  input  logic fault_i,
  input  logic intr_i,
  input  logic hit_i,
  output logic sleeping_o,
  output logic wait_done_o,
  output logic wake_o,
  output logic wake_cause_o,
  output logic fault_o
);
  mon_state_e st_q, st_d;
  logic sleep_q, sleep_d;
  logic done_d, wake_d, cause_d;
  logic armed_hit;

  assign armed_hit = (st_q == MON_ARMED) && hit_i;

  always_comb begin
    st_d    = st_q;
    sleep_d = sleep_q;
    done_d  = 1'b0;
    wake_d  = 1'b0;
    cause_d = CAUSE_STORE;
    if (sleep_q) begin
      if (armed_hit) begin
        wake_d  = 1'b1;
        cause_d = CAUSE_STORE;
        sleep_d = 1'b0;
        st_d    = MON_IDLE;
      end else if (intr_i) begin
        wake_d  = 1'b1;
        cause_d = CAUSE_INTR;
        sleep_d = 1'b0;
        st_d    = MON_IDLE;
      end
    end else if (mon_go_i) begin
      st_d = MON_ARMED;
    end else if (wait_go_i) begin
      if (st_q == MON_TRIG || armed_hit) begin
        done_d = 1'b1;
        st_d   = MON_IDLE;
      end else begin
        sleep_d = 1'b1;
      end
    end else if (armed_hit) begin
      st_d = MON_TRIG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= MON_IDLE;
      sleep_q      <= 1'b0;
      wait_done_o  <= 1'b0;
      wake_o       <= 1'b0;
      wake_cause_o <= CAUSE_STORE;
      fault_o      <= 1'b0;
    end else begin
      st_q         <= st_d;
      sleep_q      <= sleep_d;
      wait_done_o  <= done_d;
      wake_o       <= wake_d;
      wake_cause_o <= cause_d;
      fault_o      <= fault_i;
    end
  end

  assign sleeping_o = sleep_q;
endmodule

// File: rtl/addr_monitor_wake.sv
module addr_monitor_wake #(
  parameter int         ADDR_W     = 32,
  parameter int         LINE_BYTES = 64,
  parameter int         PRIV_W     = 2,
  parameter int         MT_W       = 3,
  parameter logic [2:0] MT_WB      = 3'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              mon_valid_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic              wait_valid_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [MT_W-1:0]   snp_mtype_i,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_class_i,
  output logic              sleeping_o,
  output logic              wait_done_o,
  output logic              wake_o,
  output logic              wake_cause_o,
  output logic              fault_o
);
  logic mon_go, wait_go, fault_now, intr, hit;

  amw_in_gate #(.PRIV_W(PRIV_W)) u_gate (
    .sleeping_i  (sleeping_o),
    .priv_i      (priv_i),
    .mon_valid_i (mon_valid_i),
    .wait_valid_i(wait_valid_i),
    .evt_valid_i (evt_valid_i),
    .evt_class_i (evt_class_i),
    .mon_go_o    (mon_go),
    .wait_go_o   (wait_go),
    .fault_o     (fault_now),
    .intr_o      (intr)
  );

  amw_line_match #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .MT_W      (MT_W),
    .MT_WB     (MT_WB)
  ) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mon_go),
    .load_addr_i(mon_addr_i),
    .snp_valid_i(snp_valid_i),
    .snp_addr_i (snp_addr_i),
    .snp_mtype_i(snp_mtype_i),
    .hit_o      (hit)
  );

  amw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mon_go_i    (mon_go),
    .wait_go_i   (wait_go),
    .fault_i     (fault_now),
    .intr_i      (intr),
    .hit_i       (hit),
    .sleeping_o  (sleeping_o),
    .wait_done_o (wait_done_o),
    .wake_o      (wake_o),
    .wake_cause_o(wake_cause_o),
    .fault_o     (fault_o)
  );
endmodule

// File: rtl/amw_checker.sv
module amw_checker #(
  parameter int PRIV_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PRIV_W-1:0] priv_i,
  input logic              mon_valid_i,
  input logic              wait_valid_i,
  input logic              sleeping_o,
  input logic              wait_done_o,
  input logic              wake_o,
  input logic              fault_o
);
  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);  // R6
  AST_WAKE_ENDS_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!sleeping_o && $past(sleeping_o)));  // R6
  AST_DONE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |-> (!sleeping_o && !$past(sleeping_o)));  // R5
  AST_FAULT_KEEPS_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!sleeping_o && $past(priv_i) != '0));  // R11
  AST_SLEEP_NEEDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleeping_o) |-> ($past(wait_valid_i) && !$past(mon_valid_i) && $past(priv_i) == '0));  // R13
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wake_o, wait_done_o, fault_o}));  // R12
endmodule

bind addr_monitor_wake amw_checker #(.PRIV_W(PRIV_W)) u_chk (.*);

// File: tb/addr_monitor_wake_tb.sv
`timescale 1ns/1ps
module addr_monitor_wake_tb;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    priv_i = '0;
  logic          mon_valid_i = 1'b0;
  logic [AW-1:0] mon_addr_i = '0;
  logic          wait_valid_i = 1'b0;
  logic          snp_valid_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic [2:0]    snp_mtype_i = '0;
  logic          evt_valid_i = 1'b0;
  logic [1:0]    evt_class_i = '0;
  logic          sleeping_o, wait_done_o, wake_o, wake_cause_o, fault_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // reference state: 0 disarmed, 1 armed, 2 triggered
  int            m_st = 0;
  bit            m_sleep = 0;
  logic [AW-7:0] m_line = '0;
  bit            e_done, e_wake, e_cause, e_fault;
  string         m_tag;

  always #2 clk_i = ~clk_i;

  addr_monitor_wake #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit mon, input bit wt, input logic [1:0] pv, input logic [AW-1:0] ma,
                       input bit snp, input logic [AW-1:0] sa, input logic [2:0] mt,
                       input bit ev, input logic [1:0] ec);
    bit hit_arm, intr, ok;
    hit_arm = snp && (mt == 3'd6) && (sa[AW-1:6] == m_line) && (m_st == 1);
    intr    = ev && (ec <= 2'd1);
    ok      = (pv == 2'd0);
    e_done = 0; e_wake = 0; e_cause = 0; e_fault = 0;
    m_tag = "R2";
    if (m_sleep) begin
      m_tag = (mon || wt) ? "R12" : (m_st == 0 ? "R7" : "R6");
      if (hit_arm) begin
        e_wake = 1; e_cause = 0; m_sleep = 0; m_st = 0; m_tag = intr ? "R8" : "R6";
      end else if (intr) begin
        e_wake = 1; e_cause = 1; m_sleep = 0; m_st = 0; m_tag = "R8";
      end
    end else begin
      if ((mon || wt) && !ok) begin e_fault = 1; m_tag = "R11"; end
      if (mon && ok) begin
        m_st = 1; m_line = ma[AW-1:6]; m_tag = (wt || snp) ? "R13" : "R2";
      end else if (wt && ok) begin
        if (m_st == 2 || hit_arm) begin e_done = 1; m_st = 0; m_tag = "R5"; end
        else begin m_sleep = 1; m_tag = (m_st == 0) ? "R9" : "R6"; end
      end else if (hit_arm) begin
        m_st = 2;
      end else if (ev && !intr) begin
        m_tag = "R10";
      end else if (snp && m_st == 1) begin
        m_tag = (mt != 3'd6) ? "R4" : "R3";
      end
    end
  endtask

  task automatic step(input bit mon, input bit wt, input logic [1:0] pv, input logic [AW-1:0] ma,
                      input bit snp, input logic [AW-1:0] sa, input logic [2:0] mt,
                      input bit ev, input logic [1:0] ec);
    mon_valid_i = mon; wait_valid_i = wt; priv_i = pv; mon_addr_i = ma;
    snp_valid_i = snp; snp_addr_i = sa; snp_mtype_i = mt;
    evt_valid_i = ev; evt_class_i = ec;
    model(mon, wt, pv, ma, snp, sa, mt, ev, ec);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(sleeping_o, m_sleep, m_tag, "sleeping");
    chk(wait_done_o, e_done, m_tag, "wait_done");
    chk(wake_o, e_wake, m_tag, "wake");
    chk(fault_o, e_fault, m_tag, "fault");
    if (e_wake) chk(wake_cause_o, e_cause, m_tag, "cause");
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, '0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset and right after release
    chk(sleeping_o, 0, "R1", "sleeping"); chk(wake_o, 0, "R1", "wake");
    chk(wait_done_o, 0, "R1", "wait_done"); chk(fault_o, 0, "R1", "fault");
    rst_ni = 1'b1;
    idle();

    // R2/R5: arm, store in line, wait completes at once
    step(1, 0, 0, 12'h100, 0, '0, 0, 0, 0);
    step(0, 0, 0, '0, 1, 12'h13C, 3'd6, 0, 0);
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(wait_done_o, 1, "R5", "done_direct");
    // R9/R7: no re-arm; wait sleeps, stores ignored
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(sleeping_o, 1, "R9", "sleep_after_done");
    step(0, 0, 0, '0, 1, 12'h100, 3'd6, 0, 0);
    chk(sleeping_o, 1, "R7", "store_no_wake");
    // R10: power and fault events do not wake
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd2);
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd3);
    chk(sleeping_o, 1, "R10", "evt_no_wake");
    // R8: interrupt wakes with cause 1
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd0);
    chk(wake_cause_o, 1, "R8", "cause_intr");
    // R3/R4/R6
    step(1, 0, 0, 12'h200, 0, '0, 0, 0, 0);
    step(0, 0, 0, '0, 1, 12'h240, 3'd6, 0, 0);
    step(0, 0, 0, '0, 1, 12'h210, 3'd0, 0, 0);
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(sleeping_o, 1, "R3", "miss_keeps_armed");
    step(0, 0, 0, '0, 1, 12'h23F, 3'd6, 0, 0);
    chk(wake_o, 1, "R6", "store_wake");
    chk(wake_cause_o, 0, "R6", "cause_store");
    idle();
    // R10: trigger survives side events
    step(1, 0, 0, 12'h300, 0, '0, 0, 0, 0);
    step(0, 0, 0, '0, 1, 12'h301, 3'd6, 0, 0);
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd3);
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd2);
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(wait_done_o, 1, "R10", "trig_kept");
    // R11: refused monitor leaves line unchanged
    step(1, 0, 0, 12'h500, 0, '0, 0, 0, 0);
    step(1, 0, 3, 12'h400, 0, '0, 0, 0, 0);
    chk(fault_o, 1, "R11", "fault_pulse");
    step(0, 0, 0, '0, 1, 12'h400, 3'd6, 0, 0);
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(sleeping_o, 1, "R11", "old_line_kept");
    step(0, 0, 0, '0, 1, 12'h520, 3'd6, 0, 0);
    // R12: commands while asleep ignored
    step(1, 0, 0, 12'h600, 0, '0, 0, 0, 0);
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    step(1, 0, 2, 12'h700, 0, '0, 0, 0, 0);
    chk(fault_o, 0, "R12", "no_fault_asleep");
    step(0, 0, 0, '0, 1, 12'h700, 3'd6, 0, 0);
    chk(sleeping_o, 1, "R12", "line_unchanged");
    // R8: store and interrupt together -> cause 0
    step(0, 0, 0, '0, 1, 12'h600, 3'd6, 1, 2'd1);
    chk(wake_cause_o, 0, "R8", "store_priority");
    // R13: monitor with wait and store same cycle
    step(1, 1, 0, 12'h800, 1, 12'h800, 3'd6, 0, 0);
    chk(sleeping_o, 0, "R13", "wait_dropped");
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    chk(sleeping_o, 1, "R13", "store_not_matched");
    step(0, 0, 0, '0, 0, '0, 0, 1, 2'd0);

    // random mix
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      bit mon, wt, snp, ev;
      logic [1:0] pv, ec;
      logic [AW-1:0] ma, sa;
      logic [2:0] mt;
      mon = ($urandom_range(0, 9) == 0);
      wt  = ($urandom_range(0, 7) == 0);
      pv  = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      ma  = {4'd0, 2'($urandom_range(0, 3)), 6'($urandom)};
      snp = ($urandom_range(0, 9) < 4);
      sa  = {4'd0, 2'($urandom_range(0, 3)), 6'($urandom)};
      mt  = ($urandom_range(0, 9) < 6) ? 3'd6 : 3'($urandom_range(0, 5));
      ev  = ($urandom_range(0, 19) == 0);
      ec  = 2'($urandom);
      step(mon, wt, pv, ma, snp, sa, mt, ev, ec);
    end

    // R1: async reset mid-run clears sleep
    step(0, 1, 0, '0, 0, '0, 0, 0, 0);
    rst_ni = 1'b0;
    #1;
    chk(sleeping_o, 0, "R1", "async_reset");
    m_st = 0; m_sleep = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule